// File: doc/BRIEF.md
# Branch and Address Generation Unit

This purely combinational unit produces every address that a single instruction of a 64-bit core can generate. Instructions are 16 bits wide and sit on 2-byte boundaries. The unit takes five inputs: the instruction address, the two register operands, an already sign-extended immediate and a 4-bit operation code. From these it computes the load/store address, the next program counter, a taken flag for control transfers, and a register writeback value for the two PC-relative operations that write a register.

Each operation class scales the immediate by its own fixed factor. Memory offsets are scaled by 8. Branches, jumps and the short PC-relative add are scaled by 2. The upper PC-relative add is scaled by 256. All sums are 64 bits wide and wrap modulo 2^64. The unit raises no overflow indication.

The unit does not decode, does not access the register file and holds no pipeline state. The surrounding pipeline chooses which of the outputs to use.

Top module: `branch_addr_unit`

## Requirements
- R1: `mem_addr_o` always equals `rb_i + 8*imm_i`, whatever the operation code.
- R2: Operation code 3 (branch if zero) asserts `taken_o` exactly when `ra_i` is zero. When taken, `next_pc_o` is `pc_i + 2*imm_i`.
- R3: Operation code 4 (branch if nonzero) asserts `taken_o` exactly when `ra_i` is not zero. When taken, `next_pc_o` is `pc_i + 2*imm_i`.
- R4: Whenever `taken_o` is low, `next_pc_o` equals `pc_i + 2`.
- R5: Operation code 5 (short PC add) drives `wb_val_o = pc_i + 2*imm_i` with `wb_valid_o` high and `taken_o` low.
- R6: Operation code 6 (upper PC add) drives `wb_val_o = pc_i + 256*imm_i` with `wb_valid_o` high and `taken_o` low.
- R7: Operation code 7 (register jump) always asserts `taken_o` with `next_pc_o = ra_i + 2*imm_i`.
- R8: Operation code 8 (relative jump) always asserts `taken_o` with `next_pc_o = pc_i + 2*imm_i`.
- R9: Operation codes 0 (none), 1 (load), 2 (store) and the unused codes 9 to 15 keep `taken_o` and `wb_valid_o` low. `wb_val_o` is zero whenever `wb_valid_o` is low.
- R10: Every sum wraps modulo 2^64. Carries and borrows past bit 63 are dropped without any indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (encoding given in R2 to R9) |
| pc_i | input | 64 | Address of the current instruction |
| ra_i | input | 64 | Value of the first register operand |
| rb_i | input | 64 | Value of the second register operand |
| imm_i | input | 64 | Immediate, already sign-extended |
| mem_addr_o | output | 64 | Load/store effective address |
| next_pc_o | output | 64 | Address of the next instruction to fetch |
| taken_o | output | 1 | Control flow is redirected |
| wb_val_o | output | 64 | PC-relative value for the register write |
| wb_valid_o | output | 1 | `wb_val_o` is to be written to the register |

## Verification
The bench targets the scale factors first. It uses the extreme immediates of each field width, because a wrong shift amount or a mixed-up scale would give the wrong address only at non-zero offsets. For the two conditional branches it drives a zero register and a register with only bit 63 set. A zero test that covers only part of the word would take the branch wrongly on the second value. To expose a carry that is kept or a sign that is extended wrongly, the bench places the instruction address at both ends of the address space with offsets that cross the boundary. The unused operation codes are also driven, to catch a decoder that lets them redirect control or request a writeback.

// File: rtl/bau_pkg.sv
package bau_pkg;

  parameter int unsigned XLEN       = 64;
  parameter int unsigned OPW        = 4;
  parameter int unsigned INSN_BYTES = 2;

  // immediate scale exponents, one per operation class
  localparam int unsigned SH_MEM   = 3;
  localparam int unsigned SH_REL   = 1;
  localparam int unsigned SH_UPPER = 8;

  typedef enum logic [OPW-1:0] {
    OP_NONE  = 4'd0,
    OP_LOAD  = 4'd1,
    OP_STORE = 4'd2,
    OP_BRZ   = 4'd3,
    OP_BRNZ  = 4'd4,
    OP_PCADD = 4'd5,
    OP_PCUP  = 4'd6,
    OP_JREG  = 4'd7,
    OP_JREL  = 4'd8
  } bau_op_e;

  // base + imm * 2^sh, modulo 2^XLEN
  function automatic logic [XLEN-1:0] scaled_sum(
    input logic [XLEN-1:0] base,
    input logic [XLEN-1:0] imm,
    input int unsigned     sh
  );
    return base + (imm << sh);
  endfunction

endpackage

// File: rtl/bau_scaled_add.sv
module bau_scaled_add
  import bau_pkg::*;
#(
  parameter int unsigned W     = XLEN,
  parameter int unsigned SHIFT = 0
) (
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] imm_i,
  output logic [W-1:0] sum_o
);

  logic [W-1:0] scaled;

  assign scaled = imm_i << SHIFT;
  assign sum_o  = base_i + scaled;

endmodule

// File: rtl/bau_ctrl.sv
module bau_ctrl
  import bau_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   ra_i,
  output logic           taken_o,
  output logic           from_reg_o,
  output logic           wb_en_o,
  output logic           wb_upper_o
);

  logic ra_zero;
  assign ra_zero = (ra_i == '0);

  always_comb begin
    taken_o    = 1'b0;
    from_reg_o = 1'b0;
    wb_en_o    = 1'b0;
    wb_upper_o = 1'b0;
    case (op_i)
      OP_BRZ:   taken_o = ra_zero;
      OP_BRNZ:  taken_o = ~ra_zero;
      OP_JREL:  taken_o = 1'b1;
      OP_JREG: begin
        taken_o    = 1'b1;
        from_reg_o = 1'b1;
      end
      OP_PCADD: wb_en_o = 1'b1;
      OP_PCUP: begin
        wb_en_o    = 1'b1;
        wb_upper_o = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/branch_addr_unit.sv
module branch_addr_unit
  import bau_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic [OPW-1:0] op_i,
  input  logic [W-1:0]   pc_i,
  input  logic [W-1:0]   ra_i,
  input  logic [W-1:0]   rb_i,
  input  logic [W-1:0]   imm_i,
  output logic [W-1:0]   mem_addr_o,
  output logic [W-1:0]   next_pc_o,
  output logic           taken_o,
  output logic [W-1:0]   wb_val_o,
  output logic           wb_valid_o
);

  localparam logic [W-1:0] STEP = W'(INSN_BYTES);

  // named internal events, observed by the bound checker
  logic [W-1:0] seq_pc;
  logic [W-1:0] rel_tgt;
  logic [W-1:0] reg_tgt;
  logic [W-1:0] upper_val;
  logic         redirect;
  logic         use_reg;
  logic         wb_en;
  logic         wb_upper;

  assign seq_pc = pc_i + STEP;

  bau_scaled_add #(.W(W), .SHIFT(SH_MEM)) u_mem (
    .base_i(rb_i), .imm_i(imm_i), .sum_o(mem_addr_o)
  );

  bau_scaled_add #(.W(W), .SHIFT(SH_REL)) u_rel (
    .base_i(pc_i), .imm_i(imm_i), .sum_o(rel_tgt)
  );

  bau_scaled_add #(.W(W), .SHIFT(SH_REL)) u_reg (
    .base_i(ra_i), .imm_i(imm_i), .sum_o(reg_tgt)
  );

  bau_scaled_add #(.W(W), .SHIFT(SH_UPPER)) u_upper (
    .base_i(pc_i), .imm_i(imm_i), .sum_o(upper_val)
  );

  bau_ctrl #(.W(W)) u_ctrl (
    .op_i       (op_i),
    .ra_i       (ra_i),
    .taken_o    (redirect),
    .from_reg_o (use_reg),
    .wb_en_o    (wb_en),
    .wb_upper_o (wb_upper)
  );

  always_comb begin
    if (!redirect)    next_pc_o = seq_pc;
    else if (use_reg) next_pc_o = reg_tgt;
    else              next_pc_o = rel_tgt;
  end

  always_comb begin
    if (!wb_en)        wb_val_o = '0;
    else if (wb_upper) wb_val_o = upper_val;
    else               wb_val_o = rel_tgt;
  end

  assign taken_o    = redirect;
  assign wb_valid_o = wb_en;

endmodule

// File: rtl/bau_checker.sv
module bau_checker
  import bau_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input logic [OPW-1:0] op_i,
  input logic [W-1:0]   pc_i,
  input logic [W-1:0]   ra_i,
  input logic [W-1:0]   rb_i,
  input logic [W-1:0]   imm_i,
  input logic [W-1:0]   mem_addr_o,
  input logic [W-1:0]   next_pc_o,
  input logic           taken_o,
  input logic [W-1:0]   wb_val_o,
  input logic           wb_valid_o,
  input logic [W-1:0]   seq_pc
);

  logic is_ctl;
  assign is_ctl = (op_i == OP_BRZ) || (op_i == OP_BRNZ) ||
                  (op_i == OP_JREG) || (op_i == OP_JREL);

  always_comb begin
    // R1: removing the base leaves the offset scaled by 8
    p_mem_offset_r1: assert ((mem_addr_o - rb_i) == (imm_i * W'(8)));
    if (op_i == OP_BRZ)
      p_brz_cond_r2: assert (taken_o == (ra_i == '0));
    if (op_i == OP_BRNZ)
      p_brnz_cond_r3: assert (taken_o == (ra_i != '0));
    if (!taken_o)
      p_fallthrough_r4: assert ((next_pc_o - pc_i) == W'(2) && next_pc_o == seq_pc);
    if (wb_valid_o)
      p_wb_no_redirect_r5: assert (!taken_o);
    if (op_i == OP_JREG || op_i == OP_JREL)
      p_jump_always_r7: assert (taken_o);
    if (!is_ctl)
      p_quiet_noctl_r9: assert (!taken_o);
    if (!wb_valid_o)
      p_wb_zero_r9: assert (wb_val_o == '0);
  end

endmodule

bind branch_addr_unit bau_checker #(.W(W)) u_bau_checker (
  .op_i       (op_i),
  .pc_i       (pc_i),
  .ra_i       (ra_i),
  .rb_i       (rb_i),
  .imm_i      (imm_i),
  .mem_addr_o (mem_addr_o),
  .next_pc_o  (next_pc_o),
  .taken_o    (taken_o),
  .wb_val_o   (wb_val_o),
  .wb_valid_o (wb_valid_o),
  .seq_pc     (seq_pc)
);

// File: tb/branch_addr_unit_bench.sv
module branch_addr_unit_bench;

  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [63:0] pc, ra, rb, imm;
  logic [63:0] mem_addr, next_pc, wb_val;
  logic        taken, wb_valid;
  int          n_run  = 0;
  int          n_fail = 0;
  bit          done   = 0;

  always #4 clk = ~clk;   // 125 MHz

  branch_addr_unit u_branch_addr_unit (
    .op_i(op), .pc_i(pc), .ra_i(ra), .rb_i(rb), .imm_i(imm),
    .mem_addr_o(mem_addr), .next_pc_o(next_pc), .taken_o(taken),
    .wb_val_o(wb_val), .wb_valid_o(wb_valid)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd3: return "R2";
      4'd4: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic int width_of(input logic [3:0] o);
    case (o)
      4'd1, 4'd2: return 5;
      4'd3, 4'd4, 4'd5, 4'd7: return 7;
      4'd6: return 8;
      default: return 12;
    endcase
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic logic [63:0] rnd_imm(input int w);
    logic signed [63:0] t;
    t = rnd64() << (64 - w);
    return t >>> (64 - w);
  endfunction

  // behavioural reference, evaluated per clock
  task automatic apply(input logic [3:0] o, input logic [63:0] p,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] i, input string tag);
    logic [63:0] e_mem, e_next, e_wb;
    logic        e_tk, e_wv;
    string       r;
    @(negedge clk);
    op = o; pc = p; ra = a; rb = b; imm = i;
    e_mem = b + i * 64'd8;
    e_tk = 1'b0; e_wv = 1'b0; e_wb = 64'd0;
    e_next = p + 64'd2;
    case (o)
      4'd3: e_tk = (a == 64'd0);
      4'd4: e_tk = (a != 64'd0);
      4'd5: begin e_wv = 1'b1; e_wb = p + i * 64'd2; end
      4'd6: begin e_wv = 1'b1; e_wb = p + i * 64'd256; end
      4'd7, 4'd8: e_tk = 1'b1;
      default: ;
    endcase
    if (e_tk) e_next = (o == 4'd7) ? a + i * 64'd2 : p + i * 64'd2;
    r = req_of(o);
    @(posedge clk);
    #1;
    chk({"R1 ", tag}, "mem_addr", mem_addr, e_mem);
    chk({r, " ", tag}, "taken", {63'd0, taken}, {63'd0, e_tk});
    chk(e_tk ? {r, " ", tag} : {"R4 ", tag}, "next_pc", next_pc, e_next);
    chk({r, " ", tag}, "wb_valid", {63'd0, wb_valid}, {63'd0, e_wv});
    chk({r, " ", tag}, "wb_val", wb_val, e_wb);
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    op = 4'd0; pc = '0; ra = '0; rb = '0; imm = '0;
    // reset-like quiet state: all zero inputs, op none (R9, R4)
    apply(4'd0, 64'd0, 64'd0, 64'd0, 64'd0, "idle");
    // R2 / R3: zero and bit-63-only registers
    apply(4'd3, 64'h1000, 64'd0, 64'd0, 64'h3f, "brz zero max");
    apply(4'd3, 64'h1000, 64'h8000_0000_0000_0000, 64'd0, 64'h3f, "brz msb");
    apply(4'd4, 64'h1000, 64'd0, 64'd0, -64'sd64, "brnz zero");
    apply(4'd4, 64'h1000, 64'h8000_0000_0000_0000, 64'd0, -64'sd64, "brnz msb");
    // R1: extreme 5-bit offsets
    apply(4'd1, 64'h0, 64'd0, 64'h200, 64'd15, "load max");
    apply(4'd2, 64'h0, 64'd0, 64'h200, -64'sd16, "store min");
    // R10: wrap at both ends of the address space
    apply(4'd8, 64'hffff_ffff_ffff_fffe, 64'd0, 64'd0, 64'd2047, "R10 jrel wrap up");
    apply(4'd8, 64'd4, 64'd0, 64'd0, -64'sd2048, "R10 jrel wrap down");
    apply(4'd6, 64'hffff_ffff_ffff_ff00, 64'd0, 64'd0, 64'd127, "R10 pcup wrap");
    apply(4'd1, 64'd0, 64'd0, 64'd8, -64'sd16, "R10 load wrap");
    apply(4'd0, 64'hffff_ffff_ffff_ffff, 64'd0, 64'd0, 64'd0, "R10 seq wrap");
    // R5 / R6 / R7 boundary immediates
    apply(4'd5, 64'h4000, 64'd0, 64'd0, -64'sd64, "pcadd min");
    apply(4'd6, 64'h4000, 64'd0, 64'd0, -64'sd128, "pcup min");
    apply(4'd7, 64'h0, 64'h10, 64'd0, -64'sd64, "jreg min");
    // R9: unused codes behave as non-control
    for (int c = 9; c < 16; c++)
      apply(4'(c), 64'h8000, 64'd0, 64'd5, 64'd3, "unused code");
    // random sweep over all codes
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] o;
      o = 4'($urandom_range(0, 15));
      apply(o, rnd64() & ~64'd1, (n % 5 == 0) ? 64'd0 : rnd64(), rnd64(),
            rnd_imm(width_of(o)), "random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule